// File: doc/BRIEF.md
# ECC RAM with Scrub Write-Back

This block is a simple dual-port memory of 512 words. Each word holds 64 data bits protected by a single-error-correcting, double-error-detecting code: 7 Hamming check bits plus one overall parity bit, giving a 72-bit stored word. The write side encodes incoming data before it is stored. The read side checks the stored word, repairs a single flipped bit in the data it returns, and reports uncorrectable errors. Reads have one cycle of latency. The error flags, the syndrome and a read-valid strobe all line up with the returned data.

Correcting only the returned data would leave the fault in the array. The block therefore writes the repaired word back to the same address in the cycle after a correctable read. This scrub write-back shares the single write port with user writes. It takes the port for one cycle and holds off the user with a ready signal. The exception is a user write to the same address in that cycle: the user write wins and the write-back is dropped. A double error blocks both the correction and the write-back.

Top module: `ecc_ram`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_valid`, `err_single` and `err_double` are 0 and `wr_ready` is 1.
- R2: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en` high. In that cycle `rd_data` shows the word last written at `rd_addr`. For an undisturbed word, both flags are 0 and `err_syndrome` is 0.
- R3: Stored word layout is a 72-bit vector. Bit 0 is the overall parity, which makes the whole word even parity. Bits 1, 2, 4, 8, 16, 32 and 64 are the check bits. Check bit k is the XOR of every position whose index has bit k set. Data bit i (0-based) sits at the i-th non-power-of-two position counting up from 3, so bit 0 is at 3, bit 1 at 5, bit 4 at 9 and bit 63 at 71.
- R4: When exactly one bit at position p (1 to 71) of a stored word is inverted, a read gives `err_single`=1, `err_double`=0, `err_syndrome`=p and the original data.
- R5: When only the parity bit (position 0) is inverted, a read gives `err_single`=1 with `err_syndrome`=0 and the original data.
- R6: When two bits of a stored word are inverted, a read gives `err_double`=1 and `err_single`=0. `rd_data` is the uncorrected stored data. No write-back happens, so a later read of that address again reports `err_double`.
- R7: After a read that reports `err_single`, the word at that address is rewritten with the corrected contents. A later read returns the same data with no error flag.
- R8: In the cycle after a correctable read, `wr_ready` is 0 unless a user write targets the read address. A user write held through that cycle is performed in the next cycle.
- R9: When a user write targets the address of a pending write-back, `wr_ready` stays 1, the user data is stored and the write-back is dropped.
- R10: A parity error whose syndrome exceeds 71 is reported as `err_double` and not as `err_single`. Example: the three check bits at positions 8, 32 and 64 inverted together give syndrome 104.
- R11: In any cycle with `rd_valid`=0, `err_single`, `err_double` and `err_syndrome` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | User write request |
| wr_addr | input | 9 | User write address |
| wr_data | input | 64 | User write data |
| wr_ready | output | 1 | User write accepted this cycle; low while a write-back holds the port |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Read address |
| rd_data | output | 64 | Read data, corrected when a single error is found |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| err_single | output | 1 | Correctable error found in this read |
| err_double | output | 1 | Uncorrectable error found in this read |
| err_syndrome | output | 7 | Syndrome of this read; position of the flipped bit for single errors |

## Verification
The hard part to reach from the ports is a stored word that differs from what the encoder produced. The write port only ever stores valid codewords, so no sequence of writes and reads can create an error. The bench therefore inverts chosen bits of the array word directly, between the write and the read. It picks positions that cover check bits, the first and last data positions, the parity bit, pairs of bits and a triple that pushes the syndrome past the last position. The arbitration cases need a user write presented in the exact cycle after a correctable read. The bench places that write either on another address, to see the stall, or on the same address, to see the user win.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

  // Position in the stored word of data bit idx: the idx-th index, counting
  // from 3 upward, that is not a power of two.
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7,
  localparam int CW_W  = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  logic [CW_W-1:0]  spread;
  logic [CHK_W-1:0] chk;

  always_comb begin
    // Place the data bits; check and parity positions stay zero for now.
    spread = '0;
    for (int i = 0; i < DATA_W; i++) spread[data_pos(i)] = data_i[i];

    // Check bit k covers every position whose index has bit k set.
    for (int k = 0; k < CHK_W; k++) begin
      chk[k] = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) == 1) chk[k] = chk[k] ^ spread[p];
      end
    end

    cw_o = spread;
    for (int k = 0; k < CHK_W; k++) cw_o[1 << k] = chk[k];
    cw_o[0] = ^cw_o[CW_W-1:1];
  end

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7,
  localparam int CW_W  = DATA_W + CHK_W + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syn_o,
  output logic              single_o,
  output logic              double_o
);

  logic            par_err;
  logic            in_range;
  logic [CW_W-1:0] fixed;

  always_comb begin
    // The syndrome is the XOR of the indices of all set positions.
    syn_o = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw_i[p]) syn_o = syn_o ^ CHK_W'(p);
    end
    par_err  = ^cw_i;
    in_range = int'(syn_o) < CW_W;

    single_o = par_err && in_range;
    double_o = ((syn_o != '0) && !par_err) || (par_err && !in_range);

    // Invert the bit that the syndrome points at. On a double error the
    // word is passed through unchanged.
    fixed = cw_i;
    for (int p = 1; p < CW_W; p++) begin
      if (single_o && (int'(syn_o) == p)) fixed[p] = ~cw_i[p];
    end

    for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[data_pos(i)];
  end

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int WORD_W = 72,
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read. A read of the address being written returns the old word.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ecc_ram.sv
module ecc_ram #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7,
  parameter int DEPTH  = 512,
  localparam int CW_W   = DATA_W + CHK_W + 1,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_single,
  output logic              err_double,
  output logic [CHK_W-1:0]  err_syndrome
);

  logic [CW_W-1:0]   user_cw;
  logic [CW_W-1:0]   scrub_cw;
  logic [CW_W-1:0]   stored_cw;
  logic [CW_W-1:0]   port_wdata;
  logic [ADDR_W-1:0] port_waddr;
  logic              port_we;
  logic [DATA_W-1:0] dec_data;
  logic [CHK_W-1:0]  dec_syn;
  logic              dec_single;
  logic              dec_double;
  logic              valid_q;
  logic [ADDR_W-1:0] raddr_q;
  logic              scrub_req;
  logic              user_hit;
  logic              scrub_take;

  // Write-side encoder
  ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_wr (
    .data_i (wr_data),
    .cw_o   (user_cw)
  );

  ecc_store #(.WORD_W(CW_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (port_we),
    .waddr (port_waddr),
    .wdata (port_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (stored_cw)
  );

  ecc_decoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .cw_i     (stored_cw),
    .data_o   (dec_data),
    .syn_o    (dec_syn),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  // Read-side encoder rebuilds a clean word from the corrected data
  ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_scrub (
    .data_i (dec_data),
    .cw_o   (scrub_cw)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) raddr_q <= rd_addr;
  end

  // Write-port arbitration: the scrub write-back wins unless the user
  // writes the same address in the same cycle.
  assign scrub_req  = valid_q && dec_single;
  assign user_hit   = wr_en && (wr_addr == raddr_q);
  assign scrub_take = scrub_req && !user_hit;

  assign wr_ready   = !scrub_take;
  assign port_we    = scrub_take || wr_en;
  assign port_waddr = scrub_take ? raddr_q  : wr_addr;
  assign port_wdata = scrub_take ? scrub_cw : user_cw;

  assign rd_valid     = valid_q;
  assign rd_data      = dec_data;
  assign err_single   = valid_q && dec_single;
  assign err_double   = valid_q && dec_double;
  assign err_syndrome = valid_q ? dec_syn : '0;

  // ---------------------------------------------------------------- checks
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!rd_valid && !err_single && !err_double && wr_ready));

  p_read_lat_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(err_single && err_double));

  p_double_keeps_port_r6: assert property (@(posedge clk) disable iff (rst)
    err_double |-> wr_ready);

  p_scrub_stalls_r8: assert property (@(posedge clk) disable iff (rst)
    (err_single && !wr_en) |-> !wr_ready);

  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (!err_single && !err_double && err_syndrome == '0));

endmodule

// File: tb/test_ecc_ram.sv
module test_ecc_ram;

  localparam int NONE = 255;

  typedef struct packed {
    logic [8:0]  a;
    logic [63:0] d;
    logic [7:0]  p1;
    logic [7:0]  p2;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{9'd5,   64'h0123_4567_89AB_CDEF, 8'd255, 8'd255},
    '{9'd7,   64'hFFFF_FFFF_FFFF_FFFF, 8'd3,   8'd255},
    '{9'd511, 64'hA5A5_5A5A_C3C3_3C3C, 8'd71,  8'd255},
    '{9'd0,   64'h0000_0000_0000_0001, 8'd64,  8'd255},
    '{9'd12,  64'hDEAD_BEEF_0BAD_F00D, 8'd0,   8'd255},
    '{9'd13,  64'h1357_9BDF_2468_ACE0, 8'd1,   8'd255},
    '{9'd20,  64'h8000_0000_0000_0000, 8'd3,   8'd6},
    '{9'd21,  64'h0F0F_0F0F_F0F0_F0F0, 8'd0,   8'd40},
    '{9'd22,  64'h7777_1111_2222_9999, 8'd33,  8'd65}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        wr_ready;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic        err_single;
  logic        err_double;
  logic [6:0]  err_syndrome;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ecc_ram i_ecc_ram (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wr_ready     (wr_ready),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .err_single   (err_single),
    .err_double   (err_double),
    .err_syndrome (err_syndrome)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Data index at a stored-word position per R3, or -1 for parity/check bits
  function automatic int idx_of_pos(input int p);
    int cnt;
    int res;
    cnt = 0;
    res = -1;
    for (int q = 3; q <= 71; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (q == p) res = cnt;
        cnt++;
      end
    end
    return res;
  endfunction

  task automatic inject(input int a, input int p);
    i_ecc_ram.u_store.mem[a][p] = ~i_ecc_ram.u_store.mem[a][p];
  endtask

  task automatic do_write(input int a, input logic [63:0] d);
    wr_en = 1'b1;
    wr_addr = 9'(a);
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic start_read(input int a);
    rd_en = 1'b1;
    rd_addr = 9'(a);
    tick();
    rd_en = 1'b0;
  endtask

  task automatic expect_clean(input string req, input logic [63:0] d);
    chk(rd_valid == 1'b1, req, 64'(rd_valid), 64'd1);
    chk(rd_data == d, req, rd_data, d);
    chk(!err_single && !err_double && err_syndrome == 7'd0, req,
        {err_single, err_double, err_syndrome}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_d;
    int          nflip;
    int          ix;

    // R1: reset state
    tick();
    chk(!rd_valid && !err_single && !err_double && wr_ready, "R1 during reset",
        {rd_valid, err_single, err_double, wr_ready}, 64'd1);
    tick();
    rst = 1'b0;
    chk(!rd_valid && !err_single && !err_double && wr_ready, "R1 after reset",
        {rd_valid, err_single, err_double, wr_ready}, 64'd1);

    // Vector table: write, disturb bits, read, read again
    for (int v = 0; v < NV; v++) begin
      do_write(int'(VECS[v].a), VECS[v].d);
      nflip = 0;
      exp_d = VECS[v].d;
      if (int'(VECS[v].p1) != NONE) begin
        inject(int'(VECS[v].a), int'(VECS[v].p1));
        nflip++;
        ix = idx_of_pos(int'(VECS[v].p1));
        if (ix >= 0) exp_d[ix] = ~exp_d[ix];
      end
      if (int'(VECS[v].p2) != NONE) begin
        inject(int'(VECS[v].a), int'(VECS[v].p2));
        nflip++;
        ix = idx_of_pos(int'(VECS[v].p2));
        if (ix >= 0) exp_d[ix] = ~exp_d[ix];
      end
      start_read(int'(VECS[v].a));
      chk(rd_valid == 1'b1, "R2 valid", 64'(rd_valid), 64'd1);
      if (nflip == 0) begin
        expect_clean("R2 clean read", VECS[v].d);
      end else if (nflip == 1) begin
        chk(err_single && !err_double, "R4 single flag",
            {err_single, err_double}, 64'd2);
        chk(err_syndrome == 7'(VECS[v].p1),
            (VECS[v].p1 == 8'd0) ? "R5 parity syndrome" : "R3 R4 syndrome",
            64'(err_syndrome), 64'(VECS[v].p1));
        chk(rd_data == VECS[v].d, "R4 corrected data", rd_data, VECS[v].d);
      end else begin
        chk(err_double && !err_single, "R6 double flag",
            {err_single, err_double}, 64'd1);
        chk(rd_data == exp_d, "R6 uncorrected data", rd_data, exp_d);
      end
      tick();
      chk(!rd_valid && !err_single && !err_double && err_syndrome == 7'd0,
          "R11 idle flags", {rd_valid, err_single, err_double, err_syndrome}, 64'd0);
      start_read(int'(VECS[v].a));
      if (nflip == 2) begin
        chk(err_double, "R6 no write-back", 64'(err_double), 64'd1);
      end else begin
        expect_clean("R7 repaired word", VECS[v].d);
      end
      tick();
    end

    // R8: write-back stalls a user write to another address
    do_write(40, 64'h1111_2222_3333_4444);
    inject(40, 9);
    start_read(40);
    wr_en = 1'b1;
    wr_addr = 9'd41;
    wr_data = 64'h5555_6666_7777_8888;
    #1;
    chk(err_single && !wr_ready, "R8 stall", {err_single, wr_ready}, 64'd2);
    tick();
    chk(wr_ready, "R8 ready after write-back", 64'(wr_ready), 64'd1);
    tick();
    wr_en = 1'b0;
    start_read(41);
    expect_clean("R8 held write done", 64'h5555_6666_7777_8888);
    tick();
    start_read(40);
    expect_clean("R8 R7 write-back done", 64'h1111_2222_3333_4444);
    tick();

    // R9: user write to the same address wins over the write-back
    do_write(50, 64'hAAAA_0000_BBBB_0000);
    inject(50, 30);
    start_read(50);
    wr_en = 1'b1;
    wr_addr = 9'd50;
    wr_data = 64'hCAFE_CAFE_CAFE_CAFE;
    #1;
    chk(wr_ready, "R9 user not stalled", 64'(wr_ready), 64'd1);
    tick();
    wr_en = 1'b0;
    start_read(50);
    expect_clean("R9 user data kept", 64'hCAFE_CAFE_CAFE_CAFE);
    tick();

    // R10: syndrome past the last position is uncorrectable
    do_write(60, 64'h0BAD_CAFE_1234_5678);
    inject(60, 8);
    inject(60, 32);
    inject(60, 64);
    start_read(60);
    chk(err_double && !err_single, "R10 out-of-range syndrome",
        {err_single, err_double}, 64'd1);
    chk(err_syndrome == 7'd104, "R10 syndrome value", 64'(err_syndrome), 64'd104);
    chk(rd_data == 64'h0BAD_CAFE_1234_5678, "R10 data untouched", rd_data,
        64'h0BAD_CAFE_1234_5678);
    tick();

    // R1: reset in mid-run clears the read side
    rd_en = 1'b1;
    rd_addr = 9'd5;
    rst = 1'b1;
    tick();
    rd_en = 1'b0;
    chk(!rd_valid && wr_ready, "R1 re-reset", {rd_valid, wr_ready}, 64'd1);
    rst = 1'b0;
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule